// File: doc/BRIEF.md
# Aligned Symbol Bit-Error Counter

This block measures bit errors on a two-bit-per-symbol (QPSK) link inside a chip. The transmit side hands it each reference symbol together with its transmit valid strobe. The receive side hands it each hard-decision symbol together with its decision valid strobe. The reference travels through an internal delay line whose depth, `REF_DELAY`, is set by the instantiating design to match the latency of the modulator, channel and slicer path. Each decision is therefore compared with the reference of the same symbol.

For every aligned symbol the block adds the number of differing bit positions (zero, one or two) to an error counter and adds two to a compared-bits counter. Both counters saturate and never wrap. The ratio between the two counts is computed by software or by slow display logic elsewhere. A synchronous clear input restarts a measurement without touching the system reset.

Top module: `ber_align_counter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both counters go to zero and every stage of the reference delay line is marked empty.
- R2: A reference symbol presented with `tx_vld` high in cycle n is compared with the decision presented in cycle n+`REF_DELAY` and with no other decision.
- R3: For a counted symbol, `err_bits` grows by the number of set bits in `tx_sym XOR rx_sym`, bit position against bit position. That number is 0, 1 or 2.
- R4: For a counted symbol, `total_bits` grows by exactly two.
- R5: A symbol is counted only when `rx_vld` is high and the aligned reference was valid. In any other cycle without clear, both counters keep their values.
- R6: `clr` high at a rising edge sets both counters to zero. It takes priority over a symbol counted in the same cycle, and it leaves the delay line untouched.
- R7: Each counter stops at its all-ones value (`CNT_W` bits, 32 by default) instead of wrapping.
- R8: When every decision equals its aligned reference, `err_bits` stays unchanged while `total_bits` keeps advancing.
- R9: A counted symbol's contribution is visible on the outputs right after the rising edge at which it was presented. The counters are registered, with one edge from input to output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous counter clear, priority over counting |
| tx_vld | input | 1 | Reference symbol valid (transmit side) |
| tx_sym | input | 2 | Reference symbol bits |
| rx_vld | input | 1 | Decision symbol valid (receive side) |
| rx_sym | input | 2 | Hard-decision symbol bits |
| err_bits | output | CNT_W | Accumulated differing bits |
| total_bits | output | CNT_W | Accumulated compared bits |

## Verification
A corrupted or mis-sized delay stage shows up as spurious error increments on `err_bits`, or as missing `total_bits` steps. This appears exactly `REF_DELAY` cycles after the affected reference entered, and one edge after the decision it meets. An error in the counter state shows on the very next edge: a wrong step size, an increment while idle, a wrap at full scale, or a missed clear. To expose alignment faults, the bench feeds decisions one cycle early and on time, with the correct depth fixed in the bench. It uses a small-width instance so that saturation is reached within a short run.

// File: rtl/ber_pkg.sv
`timescale 1ns/1ps
// Package: shared symbol type and widths for the aligned bit-error counter.
// Assumes two bits per symbol; widths derive from SYM_W.
package ber_pkg;
    localparam int SYM_W = 2;
    localparam int INC_W = $clog2(SYM_W + 1);

    typedef struct packed {
        logic             vld;
        logic [SYM_W-1:0] bits;
    } ber_sym_t;
endpackage

// File: rtl/ber_ref_delay.sv
`timescale 1ns/1ps
// Module: ber_ref_delay
// Delays a reference symbol and its valid flag by DEPTH clock cycles.
// Assumes DEPTH equals the datapath latency; DEPTH = 0 passes straight through.
module ber_ref_delay
    import ber_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  ber_sym_t sym_in,
    output ber_sym_t sym_out
);
    generate
        if (DEPTH == 0) begin : g_pass
            assign sym_out = sym_in;
        end else begin : g_shift
            ber_sym_t stg_q [DEPTH];

            // First stage captures the incoming reference; reset empties it.
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q[0] <= '0;
                else        stg_q[0] <= sym_in;
            end

            AST_STAGE0_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> stg_q[0] == $past(sym_in)); // R2

            for (genvar i = 1; i < DEPTH; i++) begin : g_stage
                // Each later stage takes the previous stage's value.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg_q[i] <= '0;
                    else        stg_q[i] <= stg_q[i-1];
                end

                AST_STAGE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
                    1'b1 |=> stg_q[i] == $past(stg_q[i-1])); // R2
            end

            assign sym_out = stg_q[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/ber_sym_compare.sv
`timescale 1ns/1ps
// Module: ber_sym_compare
// Decides whether a symbol is counted and how many of its bits differ.
// Assumes the reference input is already aligned with the decision.
module ber_sym_compare
    import ber_pkg::*;
(
    input  ber_sym_t          ref_sym,
    input  logic              dec_vld,
    input  logic [SYM_W-1:0]  dec_bits,
    output logic              hit,
    output logic [INC_W-1:0]  err_inc,
    output logic [INC_W-1:0]  bit_inc
);
    logic [SYM_W-1:0] diff;

    // Count a symbol only when both sides are valid; popcount the XOR.
    always_comb begin
        hit     = dec_vld & ref_sym.vld;
        diff    = ref_sym.bits ^ dec_bits;
        err_inc = '0;
        for (int i = 0; i < SYM_W; i++) begin
            err_inc = err_inc + INC_W'(diff[i]);
        end
        bit_inc = INC_W'(SYM_W);
    end
endmodule

// File: rtl/ber_sat_counter.sv
`timescale 1ns/1ps
// Module: ber_sat_counter
// Accumulating counter with synchronous clear that stops at all ones.
// Assumes clr has priority over en; inc is at most 2**INC_W - 1.
module ber_sat_counter #(
    parameter int CNT_W = 32,
    parameter int INC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [INC_W-1:0] inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] nxt;

    // Widened add; a carry out means the result is clamped at full scale.
    always_comb begin
        sum = {1'b0, cnt} + {{(CNT_W + 1 - INC_W){1'b0}}, inc};
        nxt = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
    end

    // Register update: reset, then clear, then enabled accumulate.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (en)  cnt <= nxt;
    end

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt == '0); // R6
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> cnt >= $past(cnt)); // R7
    AST_FULL_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt == CNT_MAX) |=> cnt == CNT_MAX); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !en) |=> $stable(cnt)); // R5
endmodule

// File: rtl/ber_align_counter.sv
`timescale 1ns/1ps
// Module: ber_align_counter (top)
// Aligns transmitted reference symbols to hard decisions through a delay line,
// then accumulates differing bits and compared bits in saturating counters.
// Assumes REF_DELAY matches the latency between tx and rx strobes.
module ber_align_counter
    import ber_pkg::*;
#(
    parameter int REF_DELAY = 3,
    parameter int CNT_W     = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tx_vld,
    input  logic [1:0]       tx_sym,
    input  logic             rx_vld,
    input  logic [1:0]       rx_sym,
    output logic [CNT_W-1:0] err_bits,
    output logic [CNT_W-1:0] total_bits
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] STEP_TOT = CNT_W'(SYM_W);

    ber_sym_t         ref_in;
    ber_sym_t         ref_aln;
    logic             hit;
    logic [INC_W-1:0] err_inc;
    logic [INC_W-1:0] bit_inc;

    // Bundle the reference input with its strobe.
    always_comb begin
        ref_in.vld  = tx_vld;
        ref_in.bits = tx_sym;
    end

    ber_ref_delay #(.DEPTH(REF_DELAY)) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .sym_in  (ref_in),
        .sym_out (ref_aln)
    );

    ber_sym_compare u_cmp (
        .ref_sym  (ref_aln),
        .dec_vld  (rx_vld),
        .dec_bits (rx_sym),
        .hit      (hit),
        .err_inc  (err_inc),
        .bit_inc  (bit_inc)
    );

    ber_sat_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_err_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .en    (hit),
        .inc   (err_inc),
        .cnt   (err_bits)
    );

    ber_sat_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_tot_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .en    (hit),
        .inc   (bit_inc),
        .cnt   (total_bits)
    );

    AST_ERR_LE_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> err_bits <= total_bits); // R3
    AST_ERR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (err_bits - $past(err_bits)) <= CNT_W'(SYM_W)); // R3
    AST_TOTAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && hit && total_bits <= CNT_MAX - STEP_TOT)
        |=> total_bits == $past(total_bits) + STEP_TOT); // R4
    AST_CLEAN_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && hit && rx_sym == ref_aln.bits) |=> $stable(err_bits)); // R8
    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |=> (err_bits == '0 && total_bits == '0)); // R1
endmodule

// File: tb/ber_align_counter_test.sv
`timescale 1ns/1ps
// Directed bench for ber_align_counter: one task per scenario.
module ber_align_counter_test;
    localparam int D  = 3;
    localparam int SW = 4;
    localparam logic [SW-1:0] SMAX = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic tx_vld = 1'b0;
    logic [1:0] tx_sym = 2'b00;
    logic rx_vld = 1'b0;
    logic [1:0] rx_sym = 2'b00;
    logic [31:0] err_bits, total_bits;
    logic [SW-1:0] err_s, tot_s;

    int checks = 0;
    int fails = 0;
    longint exp_err = 0, exp_tot = 0;
    longint exp_err_s = 0, exp_tot_s = 0;

    always #2.5 clk = ~clk;

    ber_align_counter #(.REF_DELAY(D), .CNT_W(32)) uut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .tx_vld(tx_vld), .tx_sym(tx_sym),
        .rx_vld(rx_vld), .rx_sym(rx_sym), .err_bits(err_bits), .total_bits(total_bits));

    ber_align_counter #(.REF_DELAY(D), .CNT_W(SW)) sat_uut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .tx_vld(tx_vld), .tx_sym(tx_sym),
        .rx_vld(rx_vld), .rx_sym(rx_sym), .err_bits(err_s), .total_bits(tot_s));

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint sat_add(input longint v, input longint inc, input longint mx);
        return (v + inc > mx) ? mx : v + inc;
    endfunction

    function automatic int pop2(input logic [1:0] x);
        return int'(x[0]) + int'(x[1]);
    endfunction

    // Model update for a counted symbol.
    task automatic model_count(input logic [1:0] diff);
        exp_err   = exp_err + pop2(diff);
        exp_tot   = exp_tot + 2;
        exp_err_s = sat_add(exp_err_s, pop2(diff), SMAX);
        exp_tot_s = sat_add(exp_tot_s, 2, SMAX);
    endtask

    task automatic model_clear();
        exp_err = 0; exp_tot = 0; exp_err_s = 0; exp_tot_s = 0;
    endtask

    // One cycle: drive at negedge, pass one rising edge, sample at next negedge.
    task automatic step(input logic tv, input logic [1:0] ts, input logic rv,
                        input logic [1:0] rs, input logic c);
        tx_vld = tv; tx_sym = ts; rx_vld = rv; rx_sym = rs; clr = c;
        @(posedge clk);
        @(negedge clk);
        tx_vld = 1'b0; rx_vld = 1'b0; clr = 1'b0;
    endtask

    task automatic check_all(input string req);
        check({req, " err"}, longint'(err_bits), exp_err);
        check({req, " total"}, longint'(total_bits), exp_tot);
        check({req, " err sat"}, longint'(err_s), exp_err_s);
        check({req, " total sat"}, longint'(tot_s), exp_tot_s);
    endtask

    // Stream n symbols; decisions follow D cycles later with a mask applied.
    task automatic run_stream(input int n, input int sstep, input int mstep,
                              input int moff, input string req);
        for (int k = 0; k < n + D; k++) begin
            logic [1:0] s_now, s_old, m_old;
            longint e0;
            s_now = 2'((k * sstep + 1) % 4);
            s_old = 2'(((k - D) * sstep + 1) % 4);
            m_old = 2'(((k - D) * mstep + moff) % 4);
            e0 = exp_err;
            step(k < n, (k < n) ? s_now : 2'b11, k >= D, (k >= D) ? (s_old ^ m_old) : 2'b10, 1'b0);
            if (k >= D) begin
                model_count(m_old);
                // R9: contribution visible right after the edge; R3 per-symbol step.
                check({req, " R3 R9 step"}, longint'(err_bits) - e0, pop2(m_old));
                check({req, " R4 total"}, longint'(total_bits), exp_tot);
            end
        end
    endtask

    task automatic t_reset();
        check_all("R1 reset");
    endtask

    task automatic t_clean();
        run_stream(8, 1, 0, 0, "R8 clean");
        check("R8 err stays zero", longint'(err_bits), 0);
        check_all("R4 R8 after clean");
    endtask

    task automatic t_errors();
        // Masks 00, 01, 10, 11 repeating: increments 0, 1, 1, 2.
        run_stream(8, 3, 1, 0, "R3 masks");
        check_all("R3 after masks");
    endtask

    task automatic t_align();
        // R2: reference 01 at cycle 0; an early decision must not meet it.
        step(1'b1, 2'b01, 1'b0, 2'b00, 1'b0);
        for (int k = 1; k < D - 1; k++) step(1'b0, 2'b00, 1'b0, 2'b00, 1'b0);
        step(1'b0, 2'b00, 1'b1, 2'b10, 1'b0); // cycle D-1: too early
        check_all("R2 R5 early decision ignored");
        step(1'b0, 2'b00, 1'b1, 2'b10, 1'b0); // cycle D: aligned, two bits differ
        model_count(2'b11);
        check_all("R2 aligned decision counted");
    endtask

    task automatic t_gaps();
        // R5: aligned reference valid but decision strobe low.
        step(1'b1, 2'b00, 1'b0, 2'b00, 1'b0);
        for (int k = 1; k < D; k++) step(1'b0, 2'b00, 1'b0, 2'b00, 1'b0);
        step(1'b0, 2'b00, 1'b0, 2'b11, 1'b0);
        check_all("R5 rx_vld low");
        // R5: decision valid, nothing in the delay line.
        step(1'b0, 2'b00, 1'b1, 2'b11, 1'b0);
        check_all("R5 no aligned reference");
    endtask

    task automatic t_clear();
        // R6: clear in the same cycle as an aligned, counted symbol.
        step(1'b1, 2'b00, 1'b0, 2'b00, 1'b0);
        for (int k = 1; k < D; k++) step(1'b0, 2'b00, 1'b0, 2'b00, 1'b0);
        step(1'b0, 2'b00, 1'b1, 2'b11, 1'b1);
        model_clear();
        check_all("R6 clear wins");
        // R6: delay line kept across clear; reference in flight still counts.
        step(1'b1, 2'b10, 1'b0, 2'b00, 1'b0);
        step(1'b0, 2'b00, 1'b0, 2'b00, 1'b1);
        for (int k = 2; k < D; k++) step(1'b0, 2'b00, 1'b0, 2'b00, 1'b0);
        step(1'b0, 2'b00, 1'b1, 2'b00, 1'b0);
        model_count(2'b10);
        check_all("R6 delay line survives clear");
    endtask

    task automatic t_sat();
        step(1'b0, 2'b00, 1'b0, 2'b00, 1'b1);
        model_clear();
        run_stream(10, 1, 0, 3, "R7 all-error");
        check("R7 small err saturates", longint'(err_s), longint'(SMAX));
        check("R7 small total saturates", longint'(tot_s), longint'(SMAX));
        check_all("R7 after saturation");
        step(1'b0, 2'b00, 1'b0, 2'b00, 1'b1);
        model_clear();
        check_all("R6 clear from full scale");
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_clean();
        t_errors();
        t_align();
        t_gaps();
        t_clear();
        t_sat();
        // R1: reset mid-run returns counters to zero.
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        model_clear();
        check_all("R1 reset mid-run");
        $display("Simulation finished: %0d checks, %0d errors", checks, fails);
        $finish;
    end
endmodule